// File: doc/BRIEF.md
# Pin Interrupt Control Register Bank

This block is the software-visible control word store of a pin interrupt unit that serves eight groups of 32 interrupt inputs. It keeps three 32-bit state words (enable mask, edge select and polarity invert) that software never writes directly. Each one is reached through a pair of aliased registers: a write-one-to-set register and a write-one-to-clear register, and either register of a pair reads back the same word. Four plain 32-bit registers sit beside them: request, group assignment, pin state and latch.

A simple single-cycle register bus carries a select, a write enable, a byte offset, a size code and write data. Read data and an error code come back one cycle after the access. Only full 32-bit accesses are accepted. A size error outranks an address error, and a rejected access changes no state and returns zero data. The assignment register's reset value depends on an instance number parameter. A registered interrupt output is raised whenever any request bit is also enabled in the mask.

Top module: `pin_irq_regbank`

## Requirements
- R1: Registers sit at byte offsets 0x00 mask-set, 0x04 mask-clear, 0x08 request, 0x0C assign, 0x10 edge-set, 0x14 edge-clear, 0x18 invert-set, 0x1C invert-clear, 0x20 pin-state and 0x24 latch.
- R2: A write to a set register (0x00, 0x10, 0x18) sets every bit of the internal word where the write data is 1 and leaves the other bits unchanged.
- R3: A write to a clear register (0x04, 0x14, 0x1C) clears every bit of the internal word where the write data is 1 and leaves the other bits unchanged.
- R4: A read of either register of a set/clear pair returns the current internal word (mask, edge or invert).
- R5: A write to request, assign, pin-state or latch stores the full 32-bit value, and a later read returns it.
- R6: An access whose size code is not 2'b10 (word; 2'b00 byte, 2'b01 half) is rejected with error code 2'b01 even if its offset is also invalid, and it changes no state.
- R7: A word access to an offset at or above 0x28, or one that is not a multiple of 4, is rejected with error code 2'b10 and changes no state.
- R8: A rejected access returns zero read data, and its error code is present for exactly the one cycle after the access.
- R9: After reset, assign holds 0x00000101 for instance 0 or 2, 0x01010000 for instance 1 and 0x02020303 for instance 3; all other words are zero. Any other instance number is an elaboration error.
- R10: irq_out is 1 exactly when request AND mask was nonzero in the previous cycle.
- R11: Read data and the error code appear in the cycle after the access. In a cycle with no read in the previous cycle, read data is zero, and in a cycle with no access in the previous cycle, the error code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_size | input | 2 | Access size: 00 byte, 01 half, 10 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 2 | 00 ok, 01 size error, 10 address error |
| irq_out | output | 1 | Registered request-and-mask interrupt |

## Verification
On every cycle the assertions check the set and clear effects on each internal word, that plain registers capture their write data, that size errors win over address errors, that a rejected access leaves mask and request untouched with zero data, that read data and errors are quiet when no access preceded them, and that the interrupt stays low while no enabled request exists. Only the bench's scenarios show that aliased pair registers return the same word, that the whole offset map decodes to the right registers, the reset value of assign for different instances, and the exact one-cycle latency of the interrupt on rising and falling.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_REGS  = 10;
    localparam int NUM_PAIRS = 3;
    localparam int NUM_PLAIN = 4;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic [3:0] {
        RID_MASK_SET = 4'd0,
        RID_MASK_CLR = 4'd1,
        RID_REQUEST  = 4'd2,
        RID_ASSIGN   = 4'd3,
        RID_EDGE_SET = 4'd4,
        RID_EDGE_CLR = 4'd5,
        RID_INV_SET  = 4'd6,
        RID_INV_CLR  = 4'd7,
        RID_PINSTATE = 4'd8,
        RID_LATCH    = 4'd9,
        RID_NONE     = 4'd15
    } reg_id_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'b00,
        ERR_SIZE = 2'b01,
        ERR_ADDR = 2'b10
    } err_e;

    typedef struct packed {
        logic    hit;
        logic    wr;
        reg_id_e id;
        err_e    err;
    } access_t;

    // Set-register id of state pair p (0 mask, 1 edge, 2 invert)
    function automatic reg_id_e pair_set_id(int p);
        case (p)
            0:       return RID_MASK_SET;
            1:       return RID_EDGE_SET;
            default: return RID_INV_SET;
        endcase
    endfunction

    function automatic reg_id_e pair_clr_id(int p);
        case (p)
            0:       return RID_MASK_CLR;
            1:       return RID_EDGE_CLR;
            default: return RID_INV_CLR;
        endcase
    endfunction

    // Plain register k (0 request, 1 assign, 2 pin state, 3 latch)
    function automatic reg_id_e plain_id(int k);
        case (k)
            0:       return RID_REQUEST;
            1:       return RID_ASSIGN;
            2:       return RID_PINSTATE;
            default: return RID_LATCH;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] assign_reset(int inst);
        case (inst)
            1:       return 32'h0101_0000;
            3:       return 32'h0202_0303;
            default: return 32'h0000_0101;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] plain_reset(int k, int inst);
        return (k == 1) ? assign_reset(inst) : '0;
    endfunction

endpackage

// File: rtl/pin_irq_decode.sv
module pin_irq_decode
    import pin_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output access_t           acc
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    assign word_idx = addr[ADDR_W-1:2];

    always_comb begin
        acc.hit = 1'b0;
        acc.wr  = we;
        acc.id  = RID_NONE;
        acc.err = ERR_NONE;
        if (sel) begin
            if (size != SIZE_WORD) begin
                acc.err = ERR_SIZE;
            end else if (addr[1:0] != 2'b00 || word_idx >= IDX_W'(NUM_REGS)) begin
                acc.err = ERR_ADDR;
            end else begin
                acc.hit = 1'b1;
                acc.id  = reg_id_e'(word_idx[3:0]);
            end
        end
    end

endmodule

// File: rtl/pin_irq_setclr.sv
module pin_irq_setclr #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (set_en) begin
            word_q <= word_q | wdata;
        end else if (clr_en) begin
            word_q <= word_q & ~wdata;
        end
    end

    AST_SET_BITS_HIGH: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((word_q & $past(wdata)) == $past(wdata))); // R2
    AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((word_q & ~$past(wdata)) == ($past(word_q) & ~$past(wdata)))); // R2
    AST_CLR_BITS_LOW: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ((word_q & $past(wdata)) == '0)); // R3
    AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ((word_q & ~$past(wdata)) == ($past(word_q) & ~$past(wdata)))); // R3

endmodule

// File: rtl/pin_irq_plainreg.sv
module pin_irq_plainreg #(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (wr_en) begin
            q <= wdata;
        end
    end

    AST_PLAIN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == $past(wdata))); // R5

endmodule

// File: rtl/pin_irq_regbank.sv
module pin_irq_regbank
    import pin_irq_pkg::*;
#(
    parameter int INST   = 0,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        bus_err,
    output logic              irq_out
);
    if (INST < 0 || INST > 3) begin : g_bad_inst
        $error("pin_irq_regbank: unsupported instance number");
    end

    access_t           acc;
    logic [DATA_W-1:0] pair_q  [NUM_PAIRS];
    logic [DATA_W-1:0] plain_q [NUM_PLAIN];
    logic [DATA_W-1:0] rd_val;
    logic              wr_ok;

    pin_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .size (bus_size),
        .acc  (acc)
    );

    assign wr_ok = acc.hit && acc.wr;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pin_irq_setclr #(.WIDTH(DATA_W)) u_word (
            .clk    (clk),
            .rst    (rst),
            .set_en (wr_ok && acc.id == pair_set_id(p)),
            .clr_en (wr_ok && acc.id == pair_clr_id(p)),
            .wdata  (bus_wdata),
            .word_q (pair_q[p])
        );
    end

    for (genvar k = 0; k < NUM_PLAIN; k++) begin : g_plain
        pin_irq_plainreg #(
            .WIDTH     (DATA_W),
            .RESET_VAL (plain_reset(k, INST))
        ) u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_ok && acc.id == plain_id(k)),
            .wdata (bus_wdata),
            .q     (plain_q[k])
        );
    end

    always_comb begin
        case (acc.id)
            RID_MASK_SET, RID_MASK_CLR: rd_val = pair_q[0];
            RID_EDGE_SET, RID_EDGE_CLR: rd_val = pair_q[1];
            RID_INV_SET,  RID_INV_CLR:  rd_val = pair_q[2];
            RID_REQUEST:                rd_val = plain_q[0];
            RID_ASSIGN:                 rd_val = plain_q[1];
            RID_PINSTATE:               rd_val = plain_q[2];
            RID_LATCH:                  rd_val = plain_q[3];
            default:                    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= ERR_NONE;
            irq_out   <= 1'b0;
        end else begin
            bus_rdata <= (acc.hit && !acc.wr) ? rd_val : '0;
            bus_err   <= acc.err;
            irq_out   <= |(plain_q[0] & pair_q[0]);
        end
    end

    AST_REJECT_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_err != ERR_NONE) |-> (bus_rdata == '0)); // R8
    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !bus_sel) |-> (bus_err == ERR_NONE)); // R11
    AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !(bus_sel && !bus_we)) |-> (bus_rdata == '0)); // R11
    AST_SIZE_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && bus_sel && bus_size != SIZE_WORD) |-> (bus_err == ERR_SIZE)); // R6
    AST_REJECT_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && acc.err != ERR_NONE) |-> ($stable(pair_q[0]) && $stable(plain_q[0]))); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && (plain_q[0] & pair_q[0]) == '0) |-> !irq_out); // R10

endmodule

// File: tb/pin_irq_regbank_bench.sv
module pin_irq_regbank_bench;
    localparam logic [1:0] W  = 2'b10;
    localparam logic [1:0] H  = 2'b01;
    localparam logic [1:0] B  = 2'b00;
    localparam logic [1:0] E0 = 2'b00;
    localparam logic [1:0] ES = 2'b01;
    localparam logic [1:0] EA = 2'b10;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp_d;
        logic [1:0]  exp_e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h0C, W, 32'h0, 32'h0000_0101, E0, 8'd9},  // R9 assign reset
        '{1'b0, 8'h00, W, 32'h0, 32'h0,         E0, 8'd9},  // R9 mask reset
        '{1'b1, 8'h00, W, 32'h0000_00F0, 32'h0, E0, 8'd2},  // R2
        '{1'b1, 8'h00, W, 32'h0000_0F00, 32'h0, E0, 8'd2},  // R2
        '{1'b0, 8'h04, W, 32'h0, 32'h0000_0FF0, E0, 8'd4},  // R4 alias
        '{1'b1, 8'h04, W, 32'h0000_0030, 32'h0, E0, 8'd3},  // R3
        '{1'b0, 8'h00, W, 32'h0, 32'h0000_0FC0, E0, 8'd3},  // R3
        '{1'b1, 8'h08, W, 32'hDEAD_BEEF, 32'h0, E0, 8'd5},  // R5
        '{1'b0, 8'h08, W, 32'h0, 32'hDEAD_BEEF, E0, 8'd5},  // R5
        '{1'b1, 8'h10, W, 32'hA5A5_0000, 32'h0, E0, 8'd2},  // R2 edge
        '{1'b0, 8'h14, W, 32'h0, 32'hA5A5_0000, E0, 8'd4},  // R4
        '{1'b1, 8'h14, W, 32'hFFFF_0000, 32'h0, E0, 8'd3},  // R3
        '{1'b0, 8'h10, W, 32'h0, 32'h0,         E0, 8'd3},  // R3
        '{1'b1, 8'h18, W, 32'h0000_0001, 32'h0, E0, 8'd2},  // R2 invert
        '{1'b1, 8'h1C, W, 32'h0, 32'h0,         E0, 8'd3},  // R3 zero clears nothing
        '{1'b0, 8'h18, W, 32'h0, 32'h0000_0001, E0, 8'd3},  // R3
        '{1'b0, 8'h1C, W, 32'h0, 32'h0000_0001, E0, 8'd4},  // R4
        '{1'b1, 8'h20, W, 32'h1234_5678, 32'h0, E0, 8'd5},  // R5
        '{1'b0, 8'h20, W, 32'h0, 32'h1234_5678, E0, 8'd1},  // R1 pin state
        '{1'b1, 8'h24, W, 32'h8000_0001, 32'h0, E0, 8'd5},  // R5
        '{1'b0, 8'h24, W, 32'h0, 32'h8000_0001, E0, 8'd1},  // R1 latch
        '{1'b1, 8'h0C, W, 32'h0000_0055, 32'h0, E0, 8'd5},  // R5
        '{1'b0, 8'h0C, W, 32'h0, 32'h0000_0055, E0, 8'd5},  // R5
        '{1'b0, 8'h28, W, 32'h0, 32'h0,         EA, 8'd7},  // R7
        '{1'b1, 8'h28, W, 32'hFFFF_FFFF, 32'h0, EA, 8'd7},  // R7
        '{1'b0, 8'h02, W, 32'h0, 32'h0,         EA, 8'd7},  // R7 misaligned
        '{1'b0, 8'h00, H, 32'h0, 32'h0,         ES, 8'd6},  // R6
        '{1'b0, 8'h28, B, 32'h0, 32'h0,         ES, 8'd6},  // R6 size beats address
        '{1'b1, 8'h08, H, 32'h0, 32'h0,         ES, 8'd6},  // R6
        '{1'b0, 8'h08, W, 32'h0, 32'hDEAD_BEEF, E0, 8'd6},  // R6 no change
        '{1'b1, 8'h00, B, 32'hFFFF_FFFF, 32'h0, ES, 8'd6},  // R6
        '{1'b0, 8'h00, W, 32'h0, 32'h0000_0FC0, E0, 8'd6},  // R6 no change
        '{1'b1, 8'h06, W, 32'hFFFF_FFFF, 32'h0, EA, 8'd7},  // R7
        '{1'b0, 8'h04, W, 32'h0, 32'h0000_0FC0, E0, 8'd7},  // R7 no change
        '{1'b0, 8'hFC, W, 32'h0, 32'h0,         EA, 8'd7}   // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = W;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata3;
    logic [1:0]  err0, err3;
    logic        irq0, irq3;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pin_irq_regbank #(.INST(0), .ADDR_W(8)) u_pin_irq_regbank (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rdata0), .bus_err(err0), .irq_out(irq0)
    );

    pin_irq_regbank #(.INST(3), .ADDR_W(8)) u_pin_irq_regbank_i3 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rdata3), .bus_err(err3), .irq_out(irq3)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge; return at the next falling edge,
    // where the registered response is visible.
    task automatic op(input logic we, input logic [7:0] addr,
                      input logic [1:0] size, input logic [31:0] wdata);
        bus_sel   = 1'b1;
        bus_we    = we;
        bus_addr  = addr;
        bus_size  = size;
        bus_wdata = wdata;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset rdata", rdata0, 32'h0);
        check("R9 reset err", {30'h0, err0}, 32'h0);
        check("R9 reset irq", {31'h0, irq0}, 32'h0);

        op(1'b0, 8'h0C, W, 32'h0);
        check("R9 inst0 assign", rdata0, 32'h0000_0101);
        check("R9 inst3 assign", rdata3, 32'h0202_0303);
        @(negedge clk);
        check("R11 idle rdata", rdata0, 32'h0);
        check("R11 idle err", {30'h0, err0}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].we, VECS[i].addr, VECS[i].size, VECS[i].wdata);
            checks++;
            if (rdata0 !== VECS[i].exp_d || err0 !== VECS[i].exp_e) begin
                fails++;
                $display("FAIL R%0d vec %0d actual=%h/%b expected=%h/%b",
                         VECS[i].req, i, rdata0, err0, VECS[i].exp_d, VECS[i].exp_e);
            end
        end

        // R8: error lasts one cycle
        op(1'b0, 8'h30, W, 32'h0);
        check("R8 err present", {30'h0, err0}, {30'h0, EA});
        @(negedge clk);
        check("R8 err one cycle", {30'h0, err0}, 32'h0);

        // R10: request 0xDEADBEEF & mask 0xFC0 is nonzero
        check("R10 irq high", {31'h0, irq0}, 32'h1);
        op(1'b1, 8'h08, W, 32'h0);
        check("R10 irq latency fall", {31'h0, irq0}, 32'h1);
        @(negedge clk);
        check("R10 irq fallen", {31'h0, irq0}, 32'h0);
        op(1'b1, 8'h08, W, 32'h0000_0040);
        check("R10 irq latency rise", {31'h0, irq0}, 32'h0);
        @(negedge clk);
        check("R10 irq risen", {31'h0, irq0}, 32'h1);
        op(1'b1, 8'h04, W, 32'h0000_0040);
        @(negedge clk);
        check("R10 irq masked off", {31'h0, irq0}, 32'h0);
        op(1'b1, 8'h08, W, 32'h0000_0001);
        @(negedge clk);
        check("R10 unmasked request no irq", {31'h0, irq0}, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule